// File: doc/BRIEF.md
# Multi-lane Serial Flash Read Host

This block is the host side of a serial flash read path. A client hands it one request holding a command selector, a 24-bit start address, a byte count and a continuous-read flag. The block then frames one transaction on the flash pins. It drives chip select low, clocks SCK in SPI mode 0, and sends the opcode, address, mode byte and dummy clocks. Each phase uses the lane width that the selected command defines. After a bus turnaround, it assembles the bytes returned by the flash and hands them on a valid/ready stream.

The seven read formats run from a plain single-lane read to a quad I/O word read. The formats that carry a mode byte can leave the flash in continuous-read mode. When that mode is armed, the next request for the same command omits the 8-clock opcode phase and starts directly with the address. SCK comes from the system clock through a runtime-selectable half-period. When the consumer stalls, SCK is parked low at a byte boundary, so no received data is lost.

Top module: `sfr_host`

## Requirements
- R1: After reset, chip select is high, SCK is low, no IO lane is driven, rd_valid is low and req_ready is high.
- R2: Unless it is omitted (R9), the opcode is sent first. It takes 8 SCK clocks on IO0 only, most significant bit first, and only IO0 is driven.
- R3: The 24-bit address is sent most significant bit first. It takes 24, 12 or 6 clocks on 1, 2 or 4 lanes. Within each clock the higher bits sit on the higher-numbered lane, so on two lanes the higher bit is on IO1 and on four lanes IO3 carries the highest bit. Only the lanes in use are driven.
- R4: Command codes on req_cmd, written as opcode, address lanes, mode byte, dummy clocks and data lanes:
  - 0: 03h, 1, no mode byte, 0 dummy clocks, 1 data lane.
  - 1: 0Bh, 1, no mode byte, 8 dummy clocks, 1 data lane.
  - 2: 3Bh, 1, no mode byte, 8 dummy clocks, 2 data lanes.
  - 3: 6Bh, 1, no mode byte, 8 dummy clocks, 4 data lanes.
  - 4: BBh, 2, mode byte, 0 dummy clocks, 2 data lanes.
  - 5: EBh, 4, mode byte, 4 dummy clocks, 4 data lanes.
  - 6: E7h, 4, mode byte, 2 dummy clocks, 4 data lanes.
  - 7: behaves as code 0.
- R5: For commands 4 to 6, a mode byte follows the address in the address lane width. The byte is CONT_MODE (default A0h) when req_cont is set and EXIT_MODE (default FFh) otherwise.
- R6: During dummy clocks and the data phase, the host drives no lane.
- R7: Received bytes are assembled most significant bit first. One-lane data is taken from IO1. Two-lane data takes the higher bit from IO1 each clock. Four-lane data takes the upper nibble from IO3..IO0 on the first clock.
- R8: A transaction has exactly opcode + address + mode + dummy + bytes*8/data_lanes SCK clocks, with the opcode term 0 when it is omitted.
- R9: A request with req_cont set on command 4, 5 or 6 arms continuous mode. The next request for that same command omits the opcode. Any request with req_cont clear disarms it, and that request still omits the opcode if it was armed. On commands 0 to 3, req_cont has no effect.
- R10: SCK stays high for exactly sck_half system clock cycles, where a value of 0 counts as 1.
- R11: While a received byte waits with rd_ready low, rd_valid and rd_data hold steady. The next byte's clocks do not start, and SCK stays low.
- R12: Chip select rises right after the final data clock. Between transactions it stays high for at least CS_GAP+1 system clock cycles (default CS_GAP 3).
- R13: A request delivers exactly req_len+1 bytes, read from consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_half | input | DIV_W | SCK half-period in system clocks, held stable during a transaction |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this cycle when valid |
| req_cmd | input | 3 | Read format selector (R4) |
| req_addr | input | 24 | Start address |
| req_len | input | LEN_W | Byte count minus one |
| req_cont | input | 1 | Request continuous-read mode |
| rd_valid | output | 1 | Received byte available |
| rd_ready | input | 1 | Consumer takes the byte |
| rd_data | output | 8 | Received byte |
| flash_cs_n | output | 1 | Chip select, active low |
| flash_sck | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables, one per lane |
| io_in | input | 4 | Lane input values |

## Verification
The hardest case to reach is the byte-boundary stall. In that case SCK must park low with the next byte not yet started while an earlier byte is held. It is reached by holding rd_ready low from the start of a multi-byte quad read. The bench then watches for 40 cycles and confirms that no SCK rise happens and the held byte stays put.

Opcode omission is the other hard case, because it depends on history rather than on the current request. A scripted sequence of armed, still-armed, disarming and plain requests is run for each mode-carrying command. A bench-side flash model decodes every transaction by counting SCK edges and capturing the lanes.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
// Shared types for the multi-lane flash read host.
package sfr_pkg;

    // Read format selector values
    typedef enum logic [2:0] {
        RD_SLOW  = 3'd0,
        RD_FAST  = 3'd1,
        RD_DOUT  = 3'd2,
        RD_QOUT  = 3'd3,
        RD_DIO   = 3'd4,
        RD_QIO   = 3'd5,
        RD_QWORD = 3'd6
    } rd_cmd_e;

    // Per-format phase description; lane widths are log2 of the lane count
    typedef struct packed {
        logic [7:0] opcode;
        logic [1:0] addr_lg;
        logic       has_mode;
        logic [3:0] dummy;
        logic [1:0] data_lg;
    } rd_prof_t;

    // Transaction sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_MODE,
        ST_DUMMY,
        ST_DATA,
        ST_GAP
    } rd_state_e;

endpackage

// File: rtl/sfr_profile.sv
`timescale 1ns/1ps
// Maps a command selector to its phase profile.
// Assumes: unknown selectors fall back to the plain single-lane read.
module sfr_profile
    import sfr_pkg::*;
(
    input  logic [2:0] cmd,
    output rd_prof_t   prof
);

    // Combinational lookup of opcode, lane widths, mode byte and dummy clocks
    always_comb begin
        case (cmd)
            RD_FAST:  prof = '{opcode: 8'h0B, addr_lg: 2'd0, has_mode: 1'b0, dummy: 4'd8, data_lg: 2'd0};
            RD_DOUT:  prof = '{opcode: 8'h3B, addr_lg: 2'd0, has_mode: 1'b0, dummy: 4'd8, data_lg: 2'd1};
            RD_QOUT:  prof = '{opcode: 8'h6B, addr_lg: 2'd0, has_mode: 1'b0, dummy: 4'd8, data_lg: 2'd2};
            RD_DIO:   prof = '{opcode: 8'hBB, addr_lg: 2'd1, has_mode: 1'b1, dummy: 4'd0, data_lg: 2'd1};
            RD_QIO:   prof = '{opcode: 8'hEB, addr_lg: 2'd2, has_mode: 1'b1, dummy: 4'd4, data_lg: 2'd2};
            RD_QWORD: prof = '{opcode: 8'hE7, addr_lg: 2'd2, has_mode: 1'b1, dummy: 4'd2, data_lg: 2'd2};
            default:  prof = '{opcode: 8'h03, addr_lg: 2'd0, has_mode: 1'b0, dummy: 4'd0, data_lg: 2'd0};
        endcase
    end

endmodule

// File: rtl/sfr_sck_gen.sv
`timescale 1ns/1ps
// SCK generator: toggles SCK every `half` system clocks while `run` is high.
// Emits one-cycle rise/fall event pulses coincident with the registered toggle.
// Assumes: half of zero is treated as one; SCK rests low when run drops.
module sfr_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             rise_evt,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half_eff;
    logic             tick;

    assign half_eff = (half == '0) ? DIV_W'(1) : half;
    assign tick     = run && (cnt == half_eff - DIV_W'(1));
    assign rise_evt = tick && !sck;
    assign fall_evt = tick && sck;

    // Half-period counter and SCK toggle register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            sck <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            sck <= ~sck;
        end else if (run) begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // The sequencer only halts SCK while it is low
    p_park_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sck);

endmodule

// File: rtl/sfr_rx_shift.sv
`timescale 1ns/1ps
// Receive assembler: shifts lane samples into a byte, most significant first.
// Assumes: sample pulses only on SCK rising edges inside the data phase.
module sfr_rx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sample,
    input  logic [1:0] lane_lg,
    input  logic [3:0] io_in,
    output logic [7:0] rx_byte
);

    // Shift in 1, 2 or 4 bits per sample according to the lane width
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte <= '0;
        end else if (sample) begin
            case (lane_lg)
                2'd0:    rx_byte <= {rx_byte[6:0], io_in[1]};
                2'd1:    rx_byte <= {rx_byte[5:0], io_in[1:0]};
                default: rx_byte <= {rx_byte[3:0], io_in};
            endcase
        end
    end

endmodule

// File: rtl/sfr_host.sv
`timescale 1ns/1ps
// Multi-lane serial flash read host.
// Frames one read transaction per request: opcode, address, optional mode
// byte, dummy clocks, then data in the lane widths of the chosen format.
// Continuous-read state is tracked here so armed requests skip the opcode.
// Assumes: sck_half stays stable during a transaction; a request in
// continuous mode keeps the command of the request that armed it.
module sfr_host
    import sfr_pkg::*;
#(
    parameter int         DIV_W     = 8,
    parameter int         LEN_W     = 8,
    parameter int         CS_GAP    = 3,
    parameter logic [7:0] CONT_MODE = 8'hA0,
    parameter logic [7:0] EXIT_MODE = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] sck_half,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_cmd,
    input  logic [23:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             req_cont,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic [7:0]       rd_data,
    output logic             flash_cs_n,
    output logic             flash_sck,
    output logic [3:0]       io_out,
    output logic [3:0]       io_oe,
    input  logic [3:0]       io_in
);

    localparam int GAP_W = $clog2(CS_GAP + 1);

    rd_state_e        state;
    rd_prof_t         prof_in;
    logic [1:0]       addr_lg;
    logic [1:0]       data_lg;
    logic             has_mode;
    logic [3:0]       dummy_n;
    logic [7:0]       opc_sr;
    logic [31:0]      tx_sr;
    logic [4:0]       ph_cnt;
    logic [LEN_W-1:0] left_q;
    logic             armed;
    logic [2:0]       armed_cmd;
    logic [GAP_W-1:0] gap_cnt;
    logic [7:0]       rx_byte;
    logic             rise_evt;
    logic             fall_evt;
    logic             run;
    logic             accept;
    logic             skip_opc;
    logic             byte_start;
    logic             byte_done;
    logic [4:0]       addr_clks;
    logic [4:0]       mode_clks;
    logic [4:0]       byte_clks;
    logic [4:0]       addr_clks_in;

    sfr_profile u_prof (
        .cmd  (req_cmd),
        .prof (prof_in)
    );

    sfr_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half     (sck_half),
        .sck      (flash_sck),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    sfr_rx_shift u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (rise_evt && state == ST_DATA),
        .lane_lg (data_lg),
        .io_in   (io_in),
        .rx_byte (rx_byte)
    );

    assign addr_clks    = 5'd24 >> addr_lg;
    assign mode_clks    = 5'd8 >> addr_lg;
    assign byte_clks    = 5'd8 >> data_lg;
    assign addr_clks_in = 5'd24 >> prof_in.addr_lg;

    assign req_ready  = (state == ST_IDLE);
    assign accept     = req_valid && req_ready;
    assign skip_opc   = armed && (armed_cmd == req_cmd) && prof_in.has_mode;
    assign flash_cs_n = (state == ST_IDLE) || (state == ST_GAP);
    assign byte_start = (state == ST_DATA) && (ph_cnt == byte_clks) && !flash_sck;
    assign byte_done  = fall_evt && (state == ST_DATA) && (ph_cnt == 5'd1);
    assign run        = !flash_cs_n && !(byte_start && rd_valid);

    // Lane drive: opcode on IO0, address and mode on the format's lanes, else released
    always_comb begin
        io_out = 4'b0000;
        io_oe  = 4'b0000;
        case (state)
            ST_OPC: begin
                io_out[0] = opc_sr[7];
                io_oe     = 4'b0001;
            end
            ST_ADDR, ST_MODE: begin
                case (addr_lg)
                    2'd0: begin
                        io_out[0] = tx_sr[31];
                        io_oe     = 4'b0001;
                    end
                    2'd1: begin
                        io_out[1:0] = tx_sr[31:30];
                        io_oe       = 4'b0011;
                    end
                    default: begin
                        io_out = tx_sr[31:28];
                        io_oe  = 4'b1111;
                    end
                endcase
            end
            default: ;
        endcase
    end

    // Transaction sequencer: request capture, phase stepping on SCK falls, gap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_lg   <= '0;
            data_lg   <= '0;
            has_mode  <= 1'b0;
            dummy_n   <= '0;
            opc_sr    <= '0;
            tx_sr     <= '0;
            ph_cnt    <= '0;
            left_q    <= '0;
            armed     <= 1'b0;
            armed_cmd <= '0;
            gap_cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state     <= skip_opc ? ST_ADDR : ST_OPC;
                        ph_cnt    <= skip_opc ? addr_clks_in : 5'd8;
                        opc_sr    <= prof_in.opcode;
                        tx_sr     <= {req_addr, req_cont ? CONT_MODE : EXIT_MODE};
                        addr_lg   <= prof_in.addr_lg;
                        data_lg   <= prof_in.data_lg;
                        has_mode  <= prof_in.has_mode;
                        dummy_n   <= prof_in.dummy;
                        left_q    <= req_len;
                        armed     <= req_cont && prof_in.has_mode;
                        armed_cmd <= req_cmd;
                    end
                end
                ST_OPC: begin
                    if (fall_evt) begin
                        opc_sr <= {opc_sr[6:0], 1'b0};
                        if (ph_cnt == 5'd1) begin
                            state  <= ST_ADDR;
                            ph_cnt <= addr_clks;
                        end else begin
                            ph_cnt <= ph_cnt - 5'd1;
                        end
                    end
                end
                ST_ADDR, ST_MODE: begin
                    if (fall_evt) begin
                        case (addr_lg)
                            2'd0:    tx_sr <= {tx_sr[30:0], 1'b0};
                            2'd1:    tx_sr <= {tx_sr[29:0], 2'b00};
                            default: tx_sr <= {tx_sr[27:0], 4'b0000};
                        endcase
                        if (ph_cnt != 5'd1) begin
                            ph_cnt <= ph_cnt - 5'd1;
                        end else if (state == ST_ADDR && has_mode) begin
                            state  <= ST_MODE;
                            ph_cnt <= mode_clks;
                        end else if (dummy_n != 4'd0) begin
                            state  <= ST_DUMMY;
                            ph_cnt <= {1'b0, dummy_n};
                        end else begin
                            state  <= ST_DATA;
                            ph_cnt <= byte_clks;
                        end
                    end
                end
                ST_DUMMY: begin
                    if (fall_evt) begin
                        if (ph_cnt == 5'd1) begin
                            state  <= ST_DATA;
                            ph_cnt <= byte_clks;
                        end else begin
                            ph_cnt <= ph_cnt - 5'd1;
                        end
                    end
                end
                ST_DATA: begin
                    if (fall_evt) begin
                        if (ph_cnt != 5'd1) begin
                            ph_cnt <= ph_cnt - 5'd1;
                        end else if (left_q == '0) begin
                            state   <= ST_GAP;
                            gap_cnt <= '0;
                        end else begin
                            left_q <= left_q - LEN_W'(1);
                            ph_cnt <= byte_clks;
                        end
                    end
                end
                ST_GAP: begin
                    if (gap_cnt == GAP_W'(CS_GAP - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output byte register: loaded at byte completion, freed by the consumer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (byte_done) begin
            rd_valid <= 1'b1;
            rd_data  <= rx_byte;
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

    // Idle bus is quiet: deselected means no drive and SCK low
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flash_cs_n |-> (io_oe == 4'b0000) && !flash_sck);

    // A transaction opens with SCK low
    p_open_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flash_cs_n) |-> !flash_sck);

    // Final clock of a byte produces a valid byte next cycle
    p_byte_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> rd_valid);

    // Held byte stays put under backpressure
    p_hold_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // A waiting byte stops the next byte from starting
    p_stall_sck_r11: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start && rd_valid && !rd_ready |=> !flash_sck);

    // Chip select high for more than one cycle after a transaction
    p_cs_gap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_cs_n) |=> flash_cs_n);

endmodule

// File: tb/sfr_host_test.sv
`timescale 1ns/1ps
module sfr_host_test;

    localparam int         DIV_W  = 8;
    localparam int         LEN_W  = 8;
    localparam int         CS_GAP = 3;
    localparam logic [7:0] CONT_M = 8'hA0;
    localparam logic [7:0] EXIT_M = 8'hFF;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic [DIV_W-1:0] sck_half;
    logic             req_valid;
    logic             req_ready;
    logic [2:0]       req_cmd;
    logic [23:0]      req_addr;
    logic [LEN_W-1:0] req_len;
    logic             req_cont;
    logic             rd_valid;
    logic             rd_ready;
    logic [7:0]       rd_data;
    logic             cs_n;
    logic             sck;
    logic [3:0]       io_out;
    logic [3:0]       io_oe;
    logic [3:0]       io_in;

    sfr_host #(.DIV_W(DIV_W), .LEN_W(LEN_W), .CS_GAP(CS_GAP),
               .CONT_MODE(CONT_M), .EXIT_MODE(EXIT_M)) uut (
        .clk(clk), .rst_n(rst_n), .sck_half(sck_half),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_len(req_len), .req_cont(req_cont),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .flash_cs_n(cs_n), .flash_sck(sck), .io_out(io_out), .io_oe(io_oe),
        .io_in(io_in)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // flash model and monitor state
    int          m_al, m_dl, m_opc_n, m_am_n, m_pre;
    int          m_rises, m_falls, oe_err;
    logic [23:0] m_addr;
    logic [7:0]  cap_opc;
    logic [31:0] cap_am;
    int          hi_len, hi_bad, cur_half;
    int          gap_len, min_gap;
    bit          seen_low;
    logic [7:0]  got [0:255];
    int          n_got;
    bit          hold_rdy;
    bit          b_armed;
    int          b_cmd;

    task automatic check(input string tag, input longint act, input longint exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
    endfunction

    // expected format table (R4)
    task automatic prof(input int c, output logic [7:0] op, output int al,
                        output bit md, output int dm, output int dl);
        case (c)
            1: begin op = 8'h0B; al = 1; md = 0; dm = 8; dl = 1; end
            2: begin op = 8'h3B; al = 1; md = 0; dm = 8; dl = 2; end
            3: begin op = 8'h6B; al = 1; md = 0; dm = 8; dl = 4; end
            4: begin op = 8'hBB; al = 2; md = 1; dm = 0; dl = 2; end
            5: begin op = 8'hEB; al = 4; md = 1; dm = 4; dl = 4; end
            6: begin op = 8'hE7; al = 4; md = 1; dm = 2; dl = 4; end
            default: begin op = 8'h03; al = 1; md = 0; dm = 0; dl = 1; end
        endcase
    endtask

    // capture host-driven lanes on SCK rise
    always @(posedge sck) begin : mon_rise
        int r;
        r = m_rises;
        if (r < m_opc_n) begin
            cap_opc = {cap_opc[6:0], io_out[0]};
            if (io_oe != 4'b0001) oe_err++;
        end else if (r < m_opc_n + m_am_n) begin
            case (m_al)
                1: begin cap_am = {cap_am[30:0], io_out[0]}; if (io_oe != 4'b0001) oe_err++; end
                2: begin cap_am = {cap_am[29:0], io_out[1:0]}; if (io_oe != 4'b0011) oe_err++; end
                default: begin cap_am = {cap_am[27:0], io_out}; if (io_oe != 4'b1111) oe_err++; end
            endcase
        end else if (io_oe != 4'b0000) begin
            oe_err++;
        end
        m_rises = r + 1;
    end

    // flash data drive on SCK fall
    always @(negedge sck) begin : drv_fall
        int d, j, g, cpb;
        logic [7:0] b;
        m_falls++;
        if (m_falls >= m_pre) begin
            d   = m_falls - m_pre;
            cpb = 8 / m_dl;
            j   = d / cpb;
            g   = d % cpb;
            b   = mem_byte(24'(m_addr + 24'(j)));
            case (m_dl)
                1: io_in = {2'b00, b[7-g], 1'b0};
                2: io_in = {2'b00, b[7-2*g], b[6-2*g]};
                default: io_in = (g == 0) ? b[7:4] : b[3:0];
            endcase
        end else begin
            io_in = 4'h0;
        end
    end

    // consumer, SCK high-time and chip-select gap monitors
    always @(negedge clk) begin : mon_clk
        rd_ready = !hold_rdy;
        if (rd_valid && rd_ready) begin
            got[n_got] = rd_data;
            n_got++;
        end
        if (sck) hi_len++;
        else begin
            if (hi_len != 0 && hi_len != cur_half) hi_bad++;
            hi_len = 0;
        end
        if (cs_n) gap_len++;
        else begin
            if (gap_len != 0 && seen_low && gap_len < min_gap) min_gap = gap_len;
            if (gap_len != 0) seen_low = 1;
            gap_len = 0;
        end
    end

    task automatic run_txn(input int c, input logic [23:0] a, input int len,
                           input bit cont, input int half, input bit bp);
        logic [7:0] op, mb;
        int al, dm, dl, r0, exp_r;
        bit md, skip;
        prof(c, op, al, md, dm, dl);
        skip    = b_armed && (b_cmd == c) && md;
        b_armed = cont && md;
        b_cmd   = c;
        mb      = cont ? CONT_M : EXIT_M;
        m_al    = al;
        m_dl    = dl;
        m_opc_n = skip ? 0 : 8;
        m_am_n  = 24 / al + (md ? 8 / al : 0);
        m_pre   = m_opc_n + m_am_n + dm;
        m_addr  = a;
        m_rises = 0; m_falls = 0; oe_err = 0; hi_bad = 0;
        cap_opc = 0; cap_am = 0; cur_half = (half == 0) ? 1 : half;
        n_got   = 0; hold_rdy = bp;
        exp_r   = m_pre + len * (8 / dl);
        @(negedge clk);
        sck_half  = DIV_W'(half);
        req_cmd   = 3'(c);
        req_addr  = a;
        req_len   = LEN_W'(len - 1);
        req_cont  = cont;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (bp) begin
            while (!rd_valid) @(negedge clk);
            r0 = m_rises;
            repeat (40) @(negedge clk);
            check("R11 byte held", rd_valid, 1);
            check("R11 no clocks while stalled", m_rises, r0);
            check("R11 sck parked low", sck, 0);
            hold_rdy = 0;
        end
        while (n_got < len || !cs_n) @(negedge clk);
        if (!skip) check($sformatf("R2 R4 opcode cmd%0d", c), cap_opc, op);
        if (md) check($sformatf("R3 R5 addr+mode cmd%0d", c), cap_am, {a, mb});
        else    check($sformatf("R3 address cmd%0d", c), cap_am[23:0], a);
        check($sformatf("R8 clock count cmd%0d", c), m_rises, exp_r);
        if (skip) check($sformatf("R9 opcode omitted cmd%0d", c), m_rises, exp_r);
        check($sformatf("R6 lane enables cmd%0d", c), oe_err, 0);
        check($sformatf("R10 sck high time half%0d", half), hi_bad, 0);
        check($sformatf("R13 byte count cmd%0d", c), n_got, len);
        for (int j = 0; j < len; j++)
            check($sformatf("R7 data cmd%0d byte%0d", c, j), got[j], mem_byte(24'(a + 24'(j))));
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : wd
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin : main
        rst_n = 0; sck_half = 2; req_valid = 0; req_cmd = 0; req_addr = 0;
        req_len = 0; req_cont = 0; io_in = 0; rd_ready = 0;
        m_al = 1; m_dl = 1; m_opc_n = 0; m_am_n = 0; m_pre = 1000;
        m_rises = 0; m_falls = 0; oe_err = 0; m_addr = 0; cap_opc = 0; cap_am = 0;
        hi_len = 0; hi_bad = 0; cur_half = 2; gap_len = 0; min_gap = 1000; seen_low = 0;
        n_got = 0; hold_rdy = 0; b_armed = 0; b_cmd = 0;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 cs_n", cs_n, 1);
        check("R1 sck", sck, 0);
        check("R1 io_oe", io_oe, 0);
        check("R1 rd_valid", rd_valid, 0);
        check("R1 req_ready", req_ready, 1);

        // sweep of all formats, divider settings and lengths
        for (int c = 0; c < 8; c++)
            for (int h = 0; h < 4; h++)
                for (int l = 0; l < 2; l++)
                    run_txn(c, 24'h123456 + 24'(c * 24'h010203) + 24'(h * 7),
                            (l == 0) ? 1 : 4, 0, h, 0);
        run_txn(5, 24'hFFFFFE, 4, 0, 1, 0);
        run_txn(0, 24'h000000, 3, 0, 2, 0);

        // R9 continuous mode sequence per mode-carrying format
        for (int c = 4; c < 7; c++) begin
            run_txn(c, 24'h00A000 + 24'(c), 2, 1, 1, 0);
            run_txn(c, 24'h00B000 + 24'(c), 2, 1, 2, 0);
            run_txn(c, 24'h00C000 + 24'(c), 2, 0, 1, 0);
            run_txn(c, 24'h00D000 + 24'(c), 2, 0, 1, 0);
        end
        // R9 continuous flag on formats without mode byte has no effect
        run_txn(1, 24'h0E0E0E, 1, 1, 1, 0);
        run_txn(1, 24'h0F0F0F, 1, 1, 1, 0);

        // R11 backpressure
        run_txn(5, 24'h345678, 3, 0, 1, 1);
        run_txn(0, 24'h456789, 3, 0, 2, 1);

        // R12 chip-select gap between back-to-back transactions
        check("R12 minimum cs_n high time", (min_gap >= CS_GAP + 1), 1);

        done = 1;
        summary();
        $finish;
    end

endmodule